// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit word register interface. A 31-bit counter advances by one on every cycle in which the low-frequency `tick` input is high, provided one of the two run bits in the configuration word is set. A programmable right shift, from 0 to 15, selects a 16-bit window of that counter. The window is compared against a 16-bit threshold. When the window reaches the threshold, the block latches a sticky pending flag that drives `irq`. If enabled, it also issues a one-cycle reset request. If zero-on-match is set, the counter clears itself.

Every write to the configuration, count, feed and threshold registers is protected by a single-use key. Writing the key word to the key register moves a small gate state machine from state SHUT to state OPEN. The first accepted protected write moves it back to SHUT. While in SHUT, protected writes are dropped. Writing any other value to the key register, or writing to the key register again while in OPEN, leaves the state unchanged. Reads are combinational from `bus_addr`. Only aligned word offsets are decoded.

Top module: `wdt_keylock`

## Requirements
- R1: After reset, the configuration word (offset 0x00) reads 0, the threshold (0x20) reads 0x0000BEEF, the key register (0x1C) reads 0, and `irq` and `rst_req` are low.
- R2: A write of 0x0051F15E to offset 0x1C moves the gate to OPEN, and 0x1C then reads 1. A write of any other value to 0x1C leaves the gate state unchanged.
- R3: While the gate is SHUT, writes to 0x00, 0x08, 0x18 and 0x20 leave every register unchanged.
- R4: An accepted write to 0x00, 0x08, 0x18 or 0x20 returns the gate to SHUT. A write to 0x10 or to an unmapped offset does not change the gate.
- R5: The count advances by one per `tick` cycle only while bit 12 (always-run) or bit 13 (run-while-awake) of 0x00 is set. Otherwise it holds.
- R6: The count at 0x08 is 31 bits wide. Bit 31 always reads 0, a written bit 31 is discarded, and the count wraps from 0x7FFFFFFF to 0.
- R7: Offset 0x10 reads the low 16 bits of the count shifted right by bits [3:0] of 0x00. Writes to 0x10 change nothing.
- R8: Offset 0x18 reads 0. An accepted write of 0x0D09F00D there clears the count. An accepted write of another value leaves the count unchanged.
- R9: When the shifted count is greater than or equal to the threshold, bit 28 of 0x00 is set on the next clock edge, and `irq` follows bit 28.
- R10: Bit 28 is sticky. It is cleared only by an accepted write to 0x00 with bit 28 at 0 while the shifted count is below the threshold.
- R11: With bit 8 of 0x00 set, `rst_req` is a single-cycle pulse one cycle after the shifted count first reaches the threshold. With bit 8 clear, `rst_req` stays low.
- R12: With bit 9 of 0x00 set, the count is cleared on the clock edge after the shifted count reaches the threshold.
- R13: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Low-frequency count enable, one pulse per count step |
| bus_we | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Follows the sticky pending bit |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 31-bit count, a 16-bit threshold and a 4-bit shift. Because the count register is writable, the wrap at 0x7FFFFFFF and the window at shift 15 are reached in a few cycles instead of billions of ticks. A threshold as small as 3 or 5 brings the match, the reset pulse, zero-on-match and the sticky flag within a dozen ticks. Random sequences of key, threshold, shift and count values then exercise the gate and the window against bench-side models.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CFG  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_CNT  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_SCL  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_FEED = 8'h18;
    localparam logic [REG_AW-1:0] OFS_KEY  = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_CMP  = 8'h20;

    localparam logic [REG_DW-1:0] KEY_WORD  = 32'h0051_F15E;
    localparam logic [REG_DW-1:0] FEED_WORD = 32'h0D09_F00D;

    // configuration word bit positions (software-visible layout)
    localparam int B_RSTEN = 8;
    localparam int B_ZERO  = 9;
    localparam int B_ALW   = 12;
    localparam int B_AWAKE = 13;
    localparam int B_PEND  = 28;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;
endpackage

// File: rtl/wdt_unlock_fsm.sv
`timescale 1ns/1ps
module wdt_unlock_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_match,
    input  logic consume,
    output logic is_open
);
    gate_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_SHUT: if (key_match) state_d = GATE_OPEN;
            GATE_OPEN: if (consume)   state_d = GATE_SHUT;
            default:                  state_d = GATE_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        is_open = (state_q == GATE_OPEN);
    end

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_match && !is_open) |=> is_open);
    assert_single_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !is_open);
endmodule

// File: rtl/wdt_count_core.sv
`timescale 1ns/1ps
module wdt_count_core #(
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               clear,
    input  logic               zero_on_hit,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CMP_W-1:0]   cmp,
    output logic [CNT_W-1:0]   count,
    output logic [CMP_W-1:0]   scaled,
    output logic               hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d;

    assign scaled = CMP_W'(count >> scale);
    assign hit    = (scaled >= cmp);

    always_comb begin
        if (load)                    count_d = load_val;
        else if (clear)              count_d = '0;
        else if (hit && zero_on_hit) count_d = '0;
        else if (run && tick)        count_d = count + ONE;
        else                         count_d = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load && !clear && !(hit && zero_on_hit)) |=> $stable(count));
    assert_zero_on_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && zero_on_hit && !load) |=> (count == '0));
endmodule

// File: rtl/wdt_keylock.sv
`timescale 1ns/1ps
module wdt_keylock
    import wdt_pkg::*;
#(
    parameter int          CNT_W   = 31,
    parameter int          CMP_W   = 16,
    parameter int          SCALE_W = 4,
    parameter logic [15:0] CMP_RST = 16'hBEEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    logic               is_open, key_match, consume, prot_sel;
    logic               wr_cfg, wr_cnt, wr_feed, wr_cmp;
    logic [SCALE_W-1:0] scale_q;
    logic               rsten_q, zero_q, alw_q, awake_q, pend_q, hit_q;
    logic [CMP_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   count;
    logic [CMP_W-1:0]   scaled;
    logic               hit;

    always_comb begin
        prot_sel = (bus_addr == OFS_CFG) || (bus_addr == OFS_CNT) ||
                   (bus_addr == OFS_FEED) || (bus_addr == OFS_CMP);
        consume  = bus_we && is_open && prot_sel;
        wr_cfg   = consume && (bus_addr == OFS_CFG);
        wr_cnt   = consume && (bus_addr == OFS_CNT);
        wr_feed  = consume && (bus_addr == OFS_FEED);
        wr_cmp   = consume && (bus_addr == OFS_CMP);
        key_match = bus_we && (bus_addr == OFS_KEY) && (bus_wdata == KEY_WORD);
    end

    wdt_unlock_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_match (key_match),
        .consume   (consume),
        .is_open   (is_open)
    );

    wdt_count_core #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .run         (alw_q || awake_q),
        .load        (wr_cnt),
        .load_val    (bus_wdata[CNT_W-1:0]),
        .clear       (wr_feed && (bus_wdata == FEED_WORD)),
        .zero_on_hit (zero_q),
        .scale       (scale_q),
        .cmp         (cmp_q),
        .count       (count),
        .scaled      (scaled),
        .hit         (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q <= '0;
            rsten_q <= 1'b0;
            zero_q  <= 1'b0;
            alw_q   <= 1'b0;
            awake_q <= 1'b0;
            pend_q  <= 1'b0;
            cmp_q   <= CMP_W'(CMP_RST);
            hit_q   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (wr_cfg) begin
                scale_q <= bus_wdata[SCALE_W-1:0];
                rsten_q <= bus_wdata[B_RSTEN];
                zero_q  <= bus_wdata[B_ZERO];
                alw_q   <= bus_wdata[B_ALW];
                awake_q <= bus_wdata[B_AWAKE];
            end
            if (wr_cmp) cmp_q <= bus_wdata[CMP_W-1:0];
            pend_q  <= hit || (wr_cfg ? bus_wdata[B_PEND] : pend_q);
            hit_q   <= hit;
            rst_req <= rsten_q && hit && !hit_q;
        end
    end

    assign irq = pend_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CFG: begin
                bus_rdata[SCALE_W-1:0] = scale_q;
                bus_rdata[B_RSTEN]     = rsten_q;
                bus_rdata[B_ZERO]      = zero_q;
                bus_rdata[B_ALW]       = alw_q;
                bus_rdata[B_AWAKE]     = awake_q;
                bus_rdata[B_PEND]      = pend_q;
            end
            OFS_CNT:  bus_rdata = REG_DW'(count);
            OFS_SCL:  bus_rdata = REG_DW'(scaled);
            OFS_KEY:  bus_rdata = REG_DW'(is_open);
            OFS_CMP:  bus_rdata = REG_DW'(cmp_q);
            default:  bus_rdata = '0;
        endcase
    end

    assert_locked_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !is_open && bus_addr == OFS_CMP) |=> $stable(cmp_q));
    assert_hit_pends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);
    assert_rst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    assert_rst_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsten_q |=> !rst_req);
endmodule

// File: tb/wdt_keylock_bench.sv
`timescale 1ns/1ps
module wdt_keylock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;
    int checks = 0;
    int fails = 0;
    logic [31:0] v;

    localparam logic [31:0] KEY  = 32'h0051_F15E;
    localparam logic [31:0] FEED = 32'h0D09_F00D;

    wdt_keylock u_wdt_keylock (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] win(input logic [31:0] c, input int s);
        logic [31:0] t;
        t = (c & 32'h7FFF_FFFF) >> s;
        return t & 32'h0000_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pwr(input logic [7:0] a, input logic [31:0] d);
        wr(8'h1C, KEY);
        wr(a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic open_m;
        logic [15:0] cmp_m;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, v); chk("R1 cfg", v, 0);
        rd(8'h20, v); chk("R1 cmp", v, 32'h0000BEEF);
        rd(8'h1C, v); chk("R1 key", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);

        // R13 and R8 read side
        rd(8'h04, v); chk("R13 0x04", v, 0);
        rd(8'h24, v); chk("R13 0x24", v, 0);
        rd(8'h18, v); chk("R8 feed reads 0", v, 0);

        // random gate traffic: R2 R3 R4
        open_m = 0; cmp_m = 16'hBEEF;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            int sel;
            sel = $urandom % 4;
            a = (sel == 0) ? 8'h1C : (sel == 1) ? 8'h20 : (sel == 2) ? 8'h10 : 8'h14;
            d = $urandom;
            if (a == 8'h1C && ($urandom % 2) == 1) d = KEY;
            wr(a, d);
            if (a == 8'h1C && d == KEY) open_m = 1;
            if (a == 8'h20 && open_m) begin cmp_m = d[15:0]; open_m = 0; end
            rd(8'h1C, v); chk("R2 R4 gate state", v, {31'b0, open_m});
            rd(8'h20, v); chk("R3 cmp value", v, {16'b0, cmp_m});
        end

        // locked writes dropped: R3
        wr(8'h1C, 32'h1234);
        rd(8'h1C, v);
        if (v == 1) pwr(8'h20, 32'h0000_0100);
        wr(8'h20, 32'h0000_7777);
        wr(8'h00, 32'h0000_300F);
        rd(8'h20, v); chk("R3 cmp locked", v, 32'h0000_0100);
        rd(8'h00, v); chk("R3 cfg locked", v & 32'h0000_FFFF, 0);

        // R7 R4: scaled reads and ignored writes
        pwr(8'h00, 32'h0000_0004);
        pwr(8'h08, 32'h0001_2345);
        wr(8'h1C, KEY);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h1C, v); chk("R4 scaled write keeps gate", v, 1);
        rd(8'h10, v); chk("R7 scale 4", v, 32'h0000_1234);
        wr(8'h14, 32'h5);
        rd(8'h1C, v); chk("R4 unmapped write keeps gate", v, 1);
        wr(8'h00, 32'h0000_000F);
        pwr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R6 bit31 dropped", v, 32'h7FFF_FFFF);
        rd(8'h10, v); chk("R7 scale 15", v, 32'h0000_FFFF);

        // random window checks R7
        for (int i = 0; i < 20; i++) begin
            int s;
            logic [31:0] c;
            s = $urandom % 16;
            c = $urandom;
            pwr(8'h00, 32'(s));
            pwr(8'h08, c);
            rd(8'h10, v); chk("R7 random window", v, win(c, s));
        end

        // R5 run bits and R6 wrap
        pwr(8'h20, 32'h0000_FFFF);
        pwr(8'h00, 32'h0);
        pwr(8'h08, 32'h0000_0010);
        ticks(3);
        rd(8'h08, v); chk("R5 hold when stopped", v, 32'h10);
        pwr(8'h00, 32'h0000_2000);
        ticks(3);
        rd(8'h08, v); chk("R5 awake bit runs", v, 32'h13);
        repeat (4) @(negedge clk);
        rd(8'h08, v); chk("R5 no tick no step", v, 32'h13);
        pwr(8'h00, 32'h0000_1000);
        pwr(8'h08, 32'h7FFF_FFFF);
        ticks(1);
        rd(8'h08, v); chk("R6 wrap", v, 0);

        // R8 feed
        pwr(8'h08, 32'h0000_0055);
        pwr(8'h18, 32'h1111_1111);
        rd(8'h08, v); chk("R8 wrong feed", v, 32'h55);
        rd(8'h1C, v); chk("R4 feed consumes key", v, 0);
        pwr(8'h18, FEED);
        rd(8'h08, v); chk("R8 feed clears", v, 0);

        // R9 R11: match with reset enable, threshold 3 at shift 2
        pwr(8'h00, 32'h0);
        pwr(8'h20, 32'h3);
        pwr(8'h18, FEED);
        pwr(8'h00, 32'h0000_1102);
        chk("R10 irq cleared", {31'b0, irq}, 0);
        ticks(11);
        chk("R9 no irq below", {31'b0, irq}, 0);
        ticks(1);
        chk("R11 no pulse yet", {31'b0, rst_req}, 0);
        @(posedge clk); #1;
        chk("R9 irq set", {31'b0, irq}, 1);
        chk("R11 pulse", {31'b0, rst_req}, 1);
        @(posedge clk); #1;
        chk("R11 pulse ends", {31'b0, rst_req}, 0);
        rd(8'h00, v); chk("R9 pending bit", v[28], 1);

        // R12 zero-on-match without reset enable
        pwr(8'h20, 32'h5);
        pwr(8'h18, FEED);
        pwr(8'h00, 32'h0000_1200);
        chk("R10 cleared by write", {31'b0, irq}, 0);
        ticks(5);
        @(posedge clk); #1;
        chk("R11 no pulse when off", {31'b0, rst_req}, 0);
        rd(8'h08, v); chk("R12 zeroed", v, 0);
        chk("R9 irq after zero", {31'b0, irq}, 1);
        repeat (5) @(negedge clk);
        chk("R10 sticky", {31'b0, irq}, 1);
        wr(8'h00, 32'h0);
        chk("R10 locked write no clear", {31'b0, irq}, 1);
        pwr(8'h00, 32'h0);
        chk("R10 unlocked clear", {31'b0, irq}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule